// File: doc/BRIEF.md
# Line-21 Closed Caption Encoder

This block produces the digital bit stream that carries closed captions on line 21 of a 525-line video signal. A host stores two 7-bit characters for each of the two fields and sets one enable bit per field. The video timing supplies a line-start pulse, the current line number and the field in progress. When the caption line of an enabled field begins, the block waits a fixed delay. It then sends seven cycles of clock run-in, a short low gap, a start bit and the two characters. Each character carries an odd-parity bit that the block computes itself.

Bit timing runs from the 13.5 MHz pixel clock. A phase accumulator divides each 858-clock line into 64 half-bit slots, which gives exactly 32 bit periods per line. At the moment a line is launched, the two characters of that field are copied into a transmit frame. Their registers then fall back to the null character, so the caption stream fills with nulls whenever the host has nothing new to send. A free-running 2-bit field counter lets the host see that a field has passed.

The output is a two-level data signal plus a strobe that marks the transmitted interval. Analog shaping and level scaling are done outside this block.

Top module: `cc_line_enc`

## Requirements
- R1: After reset, `cc_active` and `cc_data` are 0, `fld_count` is 0, both field enables are 0 (no line is sent), and all four character registers hold the null character (sent as 0x80).
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. Addresses 0 and 1 hold the first and second character of field 1, and addresses 2 and 3 hold those of field 2. Address 4 is the control word: bit 0 enables field 1 and bit 1 enables field 2. Bits 7:2 of the control word are ignored.
- R3: A line is sent only when `line_start` is high, `line_num` equals 21 and the enable of the field on `field_sel` (0 = field 1, 1 = field 2) is set. In every other case `cc_active` stays low.
- R4: `cc_active` first goes high at the 142nd rising clock edge after the edge that sampled `line_start`.
- R5: Counting from the first active cycle j = 0, half-bit slot h covers the cycles where floor(j*64/858) = h. There are 51 slots, so `cc_active` stays high for exactly 684 cycles.
- R6: Slots 0 to 12 alternate high and low, starting high. Slots 13 to 16 are low and slots 18 and 17 are high. Slots 19 to 50 carry 16 data bits, two slots each: the first character bits 0 to 6, then its parity, then the second character in the same order.
- R7: The transmitted bit 7 of each character is odd parity over bits 6:0. The host's bit 7 is ignored.
- R8: When a line is launched, both character registers of that field revert to null (data 0x00, sent as 0x80). A write in the same cycle takes precedence. Lines that are disabled or on the wrong line number leave the registers unchanged.
- R9: The characters are captured at launch. A write during the transmission does not alter the current line and is sent on the next line of that field.
- R10: `fld_count` increments by one, modulo 4, in the cycle after each change of `field_sel`. Its values 0 to 3 stand for fields 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (13.5 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | 8 | Host write data |
| line_start | input | 1 | One-cycle pulse at the horizontal reference of each line |
| line_num | input | 10 | Current line number within the field |
| field_sel | input | 1 | Current field: 0 = field 1, 1 = field 2 |
| cc_data | output | 1 | Caption waveform level |
| cc_active | output | 1 | High while the caption waveform is sent |
| fld_count | output | 2 | Field counter, 0 to 3 for fields 1 to 4 |

## Verification
The characters are chosen to have even and odd numbers of ones, to include host bit 7 both set and clear, and to include all-zero and all-one data. Comparing every active cycle against the expected waveform therefore separates a missing or inverted parity bit from a wrong bit order or a misplaced slot. Each enable pattern is tried against both fields and against a wrong line number. This shows whether gating uses the correct field's enable, and whether a skipped line leaves the stored characters in place. Back-to-back lines with no writes show the reload to null. A write in the middle of a line separates capture at launch from live reading of the registers.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

    localparam logic [6:0] NULL_DATA = 7'h00;

    // half-bit slot layout of one caption line
    localparam int RUNIN_END    = 13;   // slots 0..12 run-in
    localparam int GAP_END      = 17;   // slots 13..16 low
    localparam int START_END    = 19;   // slots 17..18 start bit
    localparam int DATA_BITS    = 16;
    localparam int FRAME_HALVES = START_END + 2 * DATA_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND
    } tx_state_e;

    function automatic logic [7:0] with_odd_parity(input logic [6:0] d);
        return {~(^d), d};
    endfunction

endpackage

// File: rtl/cc_regs.sv
module cc_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       cap_en,
    input  logic       cap_fld,
    output logic [6:0] cap_b1,
    output logic [6:0] cap_b2,
    output logic [1:0] fld_en
);
    import cc_enc_pkg::*;

    localparam logic [2:0] CTL_ADDR = 3'd4;

    typedef struct packed {
        logic [3:0][6:0] chars;
        logic [1:0]      en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_en) begin
            r_d.chars[{cap_fld, 1'b0}] = NULL_DATA;
            r_d.chars[{cap_fld, 1'b1}] = NULL_DATA;
        end
        if (wr_en) begin
            if (!wr_addr[2]) begin
                r_d.chars[wr_addr[1:0]] = wr_data[6:0];
            end else if (wr_addr == CTL_ADDR) begin
                r_d.en = wr_data[1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cap_b1 = r_q.chars[{cap_fld, 1'b0}];
    assign cap_b2 = r_q.chars[{cap_fld, 1'b1}];
    assign fld_en = r_q.en;

    // R8: a launched field falls back to null unless rewritten
    p_null_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !(wr_en && !wr_addr[2] && (wr_addr[1] == cap_fld)))
        |=> (r_q.chars[{$past(cap_fld), 1'b0}] == NULL_DATA)
         && (r_q.chars[{$past(cap_fld), 1'b1}] == NULL_DATA));

    // R7: character write keeps bits 6:0, host bit 7 dropped
    p_bit7_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[2])
        |=> ({1'b0, r_q.chars[$past(wr_addr[1:0])]} == $past(wr_data & 8'h7F)));

    // R2: control write loads the two enables only
    p_ctl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == CTL_ADDR))
        |=> ({6'b0, r_q.en} == $past(wr_data & 8'h03)));

endmodule

// File: rtl/cc_field_cnt.sv
module cc_field_cnt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_sel,
    output logic [1:0] fld_count
);

    typedef struct packed {
        logic       prev;
        logic [1:0] cnt;
    } fcnt_t;

    fcnt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = field_sel;
        if (field_sel != s_q.prev) begin
            s_d.cnt = s_q.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fld_count = s_q.cnt;

    // R10: each field change advances the counter by one
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (field_sel != s_q.prev) |=> (s_q.cnt == $past(s_q.cnt) + 2'd1));

endmodule

// File: rtl/cc_phase.sv
module cc_phase #(
    parameter int LINE_CLKS       = 858,
    parameter int HALVES_PER_LINE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);

    localparam int ACC_W = $clog2(LINE_CLKS);
    localparam logic [ACC_W:0] INC = (ACC_W + 1)'(HALVES_PER_LINE);
    localparam logic [ACC_W:0] LIM = (ACC_W + 1)'(LINE_CLKS);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } ph_t;

    ph_t p_d, p_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum  = {1'b0, p_q.acc} + INC;
        tick = (sum >= LIM);
        p_d  = p_q;
        if (clear) begin
            p_d.acc = '0;
        end else if (tick) begin
            p_d.acc = ACC_W'(sum - LIM);
        end else begin
            p_d.acc = ACC_W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    // R5: half-bit slots are many clocks long, ticks never adjacent
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> !tick);

endmodule

// File: rtl/cc_serial.sv
module cc_serial #(
    parameter int START_DLY = 142
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [6:0] b1,
    input  logic [6:0] b2,
    input  logic       tick,
    output logic       phase_clr,
    output logic       busy,
    output logic       cc_data,
    output logic       cc_active
);
    import cc_enc_pkg::*;

    localparam int DLY_W  = $clog2(START_DLY + 1);
    localparam int HIDX_W = $clog2(FRAME_HALVES);

    typedef struct packed {
        tx_state_e               state;
        logic [DLY_W-1:0]        dly;
        logic [HIDX_W-1:0]       hidx;
        logic [DATA_BITS-1:0]    frame;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        phase_clr = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (load) begin
                    s_d.state = ST_WAIT;
                    s_d.dly   = '0;
                    s_d.frame = {with_odd_parity(b2), with_odd_parity(b1)};
                end
            end
            ST_WAIT: begin
                if (s_q.dly == DLY_W'(START_DLY - 1)) begin
                    s_d.state = ST_SEND;
                    s_d.hidx  = '0;
                    phase_clr = 1'b1;
                end else begin
                    s_d.dly = s_q.dly + 1'b1;
                end
            end
            ST_SEND: begin
                if (tick) begin
                    if (s_q.hidx == HIDX_W'(FRAME_HALVES - 1)) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.hidx = s_q.hidx + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // waveform decode of the current half-bit slot
    always_comb begin
        cc_data = 1'b0;
        if (s_q.hidx < HIDX_W'(RUNIN_END)) begin
            cc_data = ~s_q.hidx[0];
        end else if (s_q.hidx < HIDX_W'(GAP_END)) begin
            cc_data = 1'b0;
        end else if (s_q.hidx < HIDX_W'(START_END)) begin
            cc_data = 1'b1;
        end else begin
            for (int k = 0; k < DATA_BITS; k++) begin
                if ((s_q.hidx == HIDX_W'(START_END + 2 * k)) ||
                    (s_q.hidx == HIDX_W'(START_END + 2 * k + 1))) begin
                    cc_data = s_q.frame[k];
                end
            end
        end
        cc_active = (s_q.state == ST_SEND);
        if (!cc_active) begin
            cc_data = 1'b0;
        end
    end

    assign busy = (s_q.state != ST_IDLE);

    // R3: a new line is only accepted when nothing is in flight
    p_load_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (s_q.state == ST_IDLE));

    // R9: captured frame stays fixed for the whole line
    p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE) |=> $stable(s_q.frame));

    // R7: both captured characters carry odd parity
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (s_q.state == ST_IDLE))
        |=> ((^s_q.frame[7:0]) && (^s_q.frame[15:8])));

    // R5: the slot index only moves on a phase tick
    p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.state == ST_SEND) && !tick) |=> $stable(s_q.hidx));

endmodule

// File: rtl/cc_line_enc.sv
module cc_line_enc #(
    parameter int LINE_CLKS       = 858,
    parameter int HALVES_PER_LINE = 64,
    parameter int START_DLY       = 142,
    parameter int CC_LINE         = 21,
    parameter int LINE_W          = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_sel,
    output logic              cc_data,
    output logic              cc_active,
    output logic [1:0]        fld_count
);

    logic [6:0] cap_b1, cap_b2;
    logic [1:0] fld_en;
    logic       busy, launch, tick, phase_clr;

    assign launch = line_start
                 && (line_num == LINE_W'(CC_LINE))
                 && fld_en[field_sel]
                 && !busy;

    cc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cap_en  (launch),
        .cap_fld (field_sel),
        .cap_b1  (cap_b1),
        .cap_b2  (cap_b2),
        .fld_en  (fld_en)
    );

    cc_field_cnt u_fcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .field_sel (field_sel),
        .fld_count (fld_count)
    );

    cc_phase #(
        .LINE_CLKS       (LINE_CLKS),
        .HALVES_PER_LINE (HALVES_PER_LINE)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (phase_clr),
        .tick  (tick)
    );

    cc_serial #(
        .START_DLY (START_DLY)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .b1        (cap_b1),
        .b2        (cap_b2),
        .tick      (tick),
        .phase_clr (phase_clr),
        .busy      (busy),
        .cc_data   (cc_data),
        .cc_active (cc_active)
    );

    // R3: strobe only rises after a launch sequence, never while idle-disabled
    p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !launch) |=> !cc_active);

endmodule

// File: tb/cc_line_enc_tb.sv
module cc_line_enc_tb;

    localparam int START_DLY = 142;
    localparam int LINE_CLKS = 858;
    localparam int HALVES    = 64;
    localparam int FRAME_LEN = 684;

    typedef struct packed {
        logic [1:0] ctl;
        logic       fld;
        logic [9:0] line;
        logic       wr;
        logic [7:0] w1;
        logic [7:0] w2;
        logic       act;
        logic [7:0] e1;
        logic [7:0] e2;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b0, 10'd21, 1'b1, 8'h14, 8'hAC, 1'b1, 8'h94, 8'h2C},
        '{2'd1, 1'b0, 10'd21, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80, 8'h80},
        '{2'd1, 1'b1, 10'd21, 1'b1, 8'h41, 8'h7F, 1'b0, 8'h00, 8'h00},
        '{2'd3, 1'b1, 10'd21, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC1, 8'h7F},
        '{2'd3, 1'b0, 10'd20, 1'b1, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00},
        '{2'd3, 1'b0, 10'd21, 1'b0, 8'h00, 8'h00, 1'b1, 8'h01, 8'h80},
        '{2'd2, 1'b0, 10'd21, 1'b1, 8'hFF, 8'h55, 1'b0, 8'h00, 8'h00},
        '{2'd2, 1'b1, 10'd21, 1'b1, 8'h00, 8'h01, 1'b1, 8'h80, 8'h01},
        '{2'd1, 1'b0, 10'd21, 1'b0, 8'h00, 8'h00, 1'b1, 8'h7F, 8'hD5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       line_start = 1'b0;
    logic [9:0] line_num = '0;
    logic       field_sel = 1'b0;
    logic       cc_data, cc_active;
    logic [1:0] fld_count;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cc_line_enc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .line_start (line_start),
        .line_num   (line_num),
        .field_sel  (field_sel),
        .cc_data    (cc_data),
        .cc_active  (cc_active),
        .fld_count  (fld_count)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected level of half-bit slot h (R6)
    function automatic logic exp_half(input int h, input logic [7:0] e1,
                                      input logic [7:0] e2);
        int k;
        if (h < 13) return (h % 2 == 0);
        if (h < 17) return 1'b0;
        if (h < 19) return 1'b1;
        k = (h - 19) / 2;
        return (k < 8) ? e1[k] : e2[k - 8];
    endfunction

    task automatic run_line(input logic fld, input logic [9:0] ln,
                            input logic exp_act, input logic [7:0] e1,
                            input logic [7:0] e2, input bit mid_wr,
                            input int id);
        int n;
        int len;
        int mism;
        field_sel = fld;
        line_num  = ln;
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        n = 0;
        while (!cc_active && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!exp_act) begin
            chk(!cc_active, "R3", $sformatf("line %0d stays silent", id),
                int'(cc_active), 0);
        end else begin
            chk(n == START_DLY, "R4", $sformatf("line %0d start delay", id),
                n, START_DLY);
            len  = 0;
            mism = 0;
            while (cc_active && len < 800) begin
                if (cc_data !== exp_half((len * HALVES) / LINE_CLKS, e1, e2))
                    mism++;
                if (mid_wr && len == 100) begin
                    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h41;
                end
                if (mid_wr && len == 101) wr_en = 1'b0;
                @(negedge clk);
                len++;
            end
            chk(len == FRAME_LEN, "R5", $sformatf("line %0d active length", id),
                len, FRAME_LEN);
            chk(mism == 0, "R6 R7",
                $sformatf("line %0d bad cycles (bytes %02h %02h)", id, e1, e2),
                mism, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // r1_ reset state
        chk(!cc_active, "R1", "active after reset", int'(cc_active), 0);
        chk(!cc_data, "R1", "data after reset", int'(cc_data), 0);
        chk(fld_count == 2'd0, "R1", "field count after reset", fld_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: counter steps on each field change, wraps after four
        for (int i = 1; i <= 4; i++) begin
            field_sel = ~field_sel;
            @(negedge clk);
            chk(fld_count == 2'(i % 4), "R10", "field count step", fld_count, i % 4);
        end
        repeat (2) @(negedge clk);
        chk(fld_count == 2'd0, "R10", "count holds without change", fld_count, 0);

        // R1: enables clear after reset, nothing sent
        run_line(1'b0, 10'd21, 1'b0, 8'h00, 8'h00, 1'b0, 100);
        // R1 R2: enable field 1, reset registers are null; upper control bits ignored
        host_wr(3'd4, 8'hFD);
        run_line(1'b0, 10'd21, 1'b1, 8'h80, 8'h80, 1'b0, 101);

        // table walk: R2 R3 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            host_wr(3'd4, {6'b0, VECS[v].ctl});
            if (VECS[v].wr) begin
                host_wr({1'b0, VECS[v].fld, 1'b0}, VECS[v].w1);
                host_wr({1'b0, VECS[v].fld, 1'b1}, VECS[v].w2);
            end
            run_line(VECS[v].fld, VECS[v].line, VECS[v].act,
                     VECS[v].e1, VECS[v].e2, 1'b0, v);
        end

        // R9: write during transmission goes to the next line
        host_wr(3'd4, 8'h01);
        host_wr(3'd0, 8'h14);
        host_wr(3'd1, 8'h2C);
        run_line(1'b0, 10'd21, 1'b1, 8'h94, 8'h2C, 1'b1, 200);
        run_line(1'b0, 10'd21, 1'b1, 8'hC1, 8'h80, 1'b0, 201);

        // R8: after the reload, a following line sends nulls
        run_line(1'b0, 10'd21, 1'b1, 8'h80, 8'h80, 1'b0, 202);

        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule